// File: doc/BRIEF.md
# Configurable UART Transmit Serializer

This block turns one parallel character into an asynchronous serial frame on a single line. Bit timing comes from an external divisor counter that delivers a 16x bit-rate enable pulse, so each bit slot spans a fixed number of those pulses. The frame is one start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a stop interval of one, one-and-a-half or two bit times.

A line-control word picks the character length, the longer stop interval, parity on or off, even or odd sense, and fixed ("stick") parity. These settings are captured with the character and held for the whole frame. A load/ready handshake takes a character only while the serializer is idle, and a busy flag stays high until the last stop slot has ended. A separate mute input pulls an auxiliary infrared output low, while the main serial line keeps sending.

Top module: `uart_tx_frame`

## Requirements
- R1: After reset `ser_out` and `ir_out` are 1, `busy` is 0 and `ld_ready` is 1; `ld_ready` is always the inverse of `busy`, and the line is 1 whenever `busy` is 0.
- R2: A character accepted on a cycle with `ld_valid` and `ld_ready` both high is framed as a 0 start bit followed by the data bits LSB first; `line_ctrl[1:0]` selects the length as 00=5, 01=6, 10=7, 11=8 bits, and the unused upper data bits are not sent.
- R3: Each start, data and parity slot lasts exactly 16 pulses of `tick16`, and `ser_out` changes only in the cycle after a consumed pulse or after an acceptance.
- R4: With `line_ctrl[2]` (longer stop) clear, the stop interval is one bit time of 16 pulses of logic 1.
- R5: With `line_ctrl[2]` set, the stop interval is 24 pulses for a 5-bit length and 32 pulses for 6, 7 or 8 bits.
- R6: With `line_ctrl[3]` (parity on) set, one parity slot sits directly after the last data bit and before the stop interval; with it clear, no parity slot is sent.
- R7: With parity on and `line_ctrl[5]` (stick) clear, `line_ctrl[4]` = 1 makes the count of ones across data and parity even, and `line_ctrl[4]` = 0 makes it odd.
- R8: With parity on and stick set, the parity bit is 0 when `line_ctrl[4]` is 1 and 1 when `line_ctrl[4]` is 0, whatever the data.
- R9: While `ir_mute` is 1, `ir_out` is 0; while it is 0, `ir_out` equals `ser_out`; `ser_out` is never affected by `ir_mute`.
- R10: While `busy` is 1, `ld_valid`, `ld_data` and `line_ctrl` have no effect on the frame in progress; `busy` falls only after the pulse that ends the final stop slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | 16x bit-rate enable pulse |
| ld_valid | input | 1 | Character offered |
| ld_ready | output | 1 | Serializer idle, character will be taken |
| ld_data | input | 8 | Character, LSB sent first |
| line_ctrl | input | 6 | Length [1:0], longer stop [2], parity on [3], even sense [4], stick [5] |
| ir_mute | input | 1 | Force infrared output low |
| ser_out | output | 1 | Serial line, idles high |
| ir_out | output | 1 | Infrared copy of the line |
| busy | output | 1 | Frame in progress |

## Verification
The line level is a decode of registered state, so it reflects an acceptance or a consumed `tick16` pulse one clock later; the bench therefore compares `ser_out` and `ir_out` on the falling edge of every busy cycle against the head of a per-pulse expectation queue, and pops an entry only on falling edges where `tick16` is high, i.e. just before that pulse is consumed. `busy` drops one clock after the pulse ending the final stop slot, so the frame length (R4, R5) is checked by finding the queue empty on the first falling edge where `busy` is low. Loads and control changes made mid-frame are checked by the same queue, which they must not disturb.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } utx_state_e;

    // Six-bit line-control word, packed MSB first.
    typedef struct packed {
        logic       par_stick;
        logic       par_even;
        logic       par_en;
        logic       stop_ext;
        logic [1:0] len;
    } utx_ctrl_t;

endpackage

// File: rtl/utx_parity.sv
module utx_parity #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len,
    input  logic              even,
    input  logic              stick,
    output logic              par_bit
);
    logic [DATA_W-1:0] mask;
    logic              ones_odd;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (i < (MIN_LEN + int'(len)));
        end
        ones_odd = ^(data & mask);
        if (stick) begin
            par_bit = ~even;
        end else begin
            par_bit = even ? ones_odd : ~ones_odd;
        end
    end
endmodule

// File: rtl/utx_ir_gate.sv
module utx_ir_gate (
    input  logic line_in,
    input  logic mute,
    output logic ir_line
);
    assign ir_line = line_in & ~mute;
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame #(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [5:0]        line_ctrl,
    input  logic              ir_mute,
    output logic              ser_out,
    output logic              ir_out,
    output logic              busy
);
    import utx_pkg::*;

    localparam int CNT_W   = $clog2(2 * OSR + 1);
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int MIN_LEN = 5;

    typedef struct packed {
        utx_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        utx_ctrl_t         ctl;
        logic              par;
        logic              busy;
    } seq_t;

    seq_t      r_q, r_d;
    utx_ctrl_t in_ctl;
    logic      par_new;
    logic      accept;
    logic [CNT_W-1:0] slot_lim;
    logic      slot_end;
    logic      last_data;

    assign in_ctl = utx_ctrl_t'(line_ctrl);
    assign accept = ld_valid & ~r_q.busy;

    utx_parity #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_par (
        .data    (ld_data),
        .len     (in_ctl.len),
        .even    (in_ctl.par_even),
        .stick   (in_ctl.par_stick),
        .par_bit (par_new)
    );

    always_comb begin
        if (r_q.st == ST_STOP && r_q.ctl.stop_ext) begin
            slot_lim = (r_q.ctl.len == 2'b00) ? CNT_W'(OSR + OSR / 2) : CNT_W'(2 * OSR);
        end else begin
            slot_lim = CNT_W'(OSR);
        end
        slot_end  = tick16 && (r_q.cnt == slot_lim - CNT_W'(1));
        last_data = (r_q.idx == IDX_W'(MIN_LEN - 1) + IDX_W'(r_q.ctl.len));
    end

    always_comb begin
        r_d = r_q;
        if (r_q.st == ST_IDLE) begin
            if (accept) begin
                r_d.st   = ST_START;
                r_d.cnt  = '0;
                r_d.idx  = '0;
                r_d.sh   = ld_data;
                r_d.ctl  = in_ctl;
                r_d.par  = par_new;
                r_d.busy = 1'b1;
            end
        end else if (tick16) begin
            if (slot_end) begin
                r_d.cnt = '0;
                case (r_q.st)
                    ST_START: begin
                        r_d.st  = ST_DATA;
                        r_d.idx = '0;
                    end
                    ST_DATA: begin
                        if (last_data) begin
                            r_d.st = r_q.ctl.par_en ? ST_PARITY : ST_STOP;
                        end else begin
                            r_d.idx = r_q.idx + IDX_W'(1);
                            r_d.sh  = r_q.sh >> 1;
                        end
                    end
                    ST_PARITY: r_d.st = ST_STOP;
                    default: begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                    end
                endcase
            end else begin
                r_d.cnt = r_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, idx: '0, sh: '0,
                     ctl: '0, par: 1'b0, busy: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            ST_START:  ser_out = 1'b0;
            ST_DATA:   ser_out = r_q.sh[0];
            ST_PARITY: ser_out = r_q.par;
            default:   ser_out = 1'b1;
        endcase
    end

    utx_ir_gate u_ir (
        .line_in (ser_out),
        .mute    (ir_mute),
        .ir_line (ir_out)
    );

    assign busy     = r_q.busy;
    assign ld_ready = ~r_q.busy;

    // R1: idle line is high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out);

    // R2: an accepted character starts with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> (busy && !ser_out));

    // R3: line moves only after a consumed pulse or an acceptance
    p_line_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick16) && !$past(ld_valid && ld_ready)) |-> $stable(ser_out));

    // R9: mute holds the infrared output low
    p_ir_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ir_mute |-> !ir_out);

    // R10: busy ends only on a pulse
    p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick16));

    // R10: no acceptance while a frame runs
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick16) |=> busy);
endmodule

// File: tb/tb_uart_tx_frame.sv
module tb_uart_tx_frame;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       ld_valid = 1'b0;
    logic       ld_ready;
    logic [7:0] ld_data = 8'h00;
    logic [5:0] line_ctrl = 6'h00;
    logic       ir_mute = 1'b0;
    logic       ser_out, ir_out, busy;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic  lvl;
        string tag;
    } slot_t;
    slot_t exp_q[$];

    always #5 clk = ~clk;

    uart_tx_frame dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
        .line_ctrl(line_ctrl), .ir_mute(ir_mute),
        .ser_out(ser_out), .ir_out(ir_out), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // pulse every fourth clock
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 4;
        tick16 = (tdiv == 0);
    end

    // monitor: compare the current slot, pop when its pulse is about to be taken
    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 frame longer than expected", 1, 0);
            end else begin
                check(ser_out === exp_q[0].lvl, exp_q[0].tag, int'(ser_out), int'(exp_q[0].lvl));
                check(ir_out === (exp_q[0].lvl & ~ir_mute), "R9 infrared line",
                      int'(ir_out), int'(exp_q[0].lvl & ~ir_mute));
                if (tick16) void'(exp_q.pop_front());
            end
        end
    end

    task automatic push_seg(input logic lvl, input int n, input string tag);
        for (int i = 0; i < n; i++) exp_q.push_back('{lvl: lvl, tag: tag});
    endtask

    task automatic send(input logic [7:0] d, input logic [5:0] c, input logic mute, input bit poke);
        int   n;
        int   ones;
        logic p;
        string stag;
        n = 5 + int'(c[1:0]);
        ones = 0;
        push_seg(1'b0, 16, "R2 start bit");
        for (int i = 0; i < n; i++) begin
            push_seg(d[i], 16, "R2 data bit");
            ones += int'(d[i]);
        end
        if (c[3]) begin
            if (c[5]) p = ~c[4];
            else p = c[4] ? logic'(ones % 2) : ~logic'(ones % 2);
            push_seg(p, 16, c[5] ? "R8 stick parity" : "R7 parity (R6 slot)");
        end
        stag = c[2] ? "R5 long stop" : "R4 single stop";
        push_seg(1'b1, c[2] ? ((n == 5) ? 24 : 32) : 16, stag);
        @(posedge clk); #1;
        check(ld_ready === 1'b1, "R1 ready when idle", int'(ld_ready), 1);
        ld_data = d; line_ctrl = c; ir_mute = mute; ld_valid = 1'b1;
        @(posedge clk); #1;
        ld_valid = 1'b0;
        if (poke) begin
            repeat (30) @(posedge clk);
            #1;
            check(ld_ready === 1'b0, "R10 ready low while busy", int'(ld_ready), 0);
            ld_data = ~d; line_ctrl = ~c; ld_valid = 1'b1;
            repeat (200) @(posedge clk);
            #1;
            ld_valid = 1'b0;
        end
        do @(negedge clk); while (busy);
        check(exp_q.size() == 0, {stag, " frame length"}, exp_q.size(), 0);
        check(ser_out === 1'b1 && ld_ready === 1'b1, "R1 idle after frame", int'(ser_out), 1);
        exp_q.delete();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(ser_out === 1'b1, "R1 reset line", int'(ser_out), 1);
        check(ir_out === 1'b1, "R1 reset ir", int'(ir_out), 1);
        check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        check(ld_ready === 1'b1, "R1 reset ready", int'(ld_ready), 1);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        send(8'hA5, 6'b000011, 1'b0, 1'b0);   // R2 R4: 8 bits, no parity
        send(8'hF3, 6'b000100, 1'b0, 1'b0);   // R5: 5 bits, 1.5 stop
        send(8'h2D, 6'b011101, 1'b0, 1'b0);   // R5 R7: 6 bits even, 2 stop
        send(8'h6B, 6'b001010, 1'b0, 1'b0);   // R6 R7: 7 bits odd
        send(8'hFF, 6'b111011, 1'b0, 1'b0);   // R8: stick, even sense -> 0
        send(8'h00, 6'b101000, 1'b0, 1'b0);   // R8: stick, odd sense -> 1
        send(8'h5A, 6'b001011, 1'b1, 1'b0);   // R9: mute on
        send(8'h3C, 6'b000001, 1'b0, 1'b1);   // R10: mid-frame load ignored
        send(8'h81, 6'b011111, 1'b0, 1'b0);   // back to back, 8 bits even, 2 stop
        repeat (10) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule